// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block sits beside the fetch stage of a pipelined core and guesses whether a conditional branch will be taken. It keeps a small, fully associative set of entries; each one remembers the full address of a branch seen recently and a two-bit signed saturating counter that tracks how that branch has behaved. Fetch presents the address of a branch on the lookup port and receives, in the same cycle, whether the address is known and which way it is predicted to go. An address that is not in the table is predicted not taken.

When the branch resolves later in the pipeline, the execute stage presents its address and real outcome on the update port. A known address has its counter stepped toward the outcome. An unknown address claims an entry: an empty one while any remain, otherwise the entry used least recently. Both a lookup hit and an update count as a use. The number of entries and the address width are parameters.

Top module: `bp_dir_table`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the table, so every lookup in the cycles after reset misses.
- R2: Lookup results are combinational on the current table contents; a miss, or `lkValid` low, drives both `lkHit` and `lkTaken` low.
- R3: An update whose address is absent allocates an entry holding that address with counter value 0 (binary 00), whatever the reported outcome; a lookup of that address in the next cycle hits and predicts taken.
- R4: The counter is two-bit two's complement (10 = -2, 11 = -1, 00 = 0, 01 = +1); a hit predicts taken exactly when the value is 0 or +1.
- R5: An update of a present address with outcome taken raises its counter by one, holding at +1; a taken update at +1 followed by one not-taken update leaves the branch predicted taken.
- R6: An update of a present address with outcome not taken lowers its counter by one, holding at -2; from -2, one taken update leaves the branch predicted not taken and a second makes it predicted taken.
- R7: While empty entries remain, an allocation never displaces a valid entry: after reset, ENTRIES distinct addresses can all be allocated and all then hit.
- R8: When the table is full, allocation evicts the entry whose last use (lookup hit or update) is oldest; lookups that miss do not count as a use.
- R9: When a lookup and an update address the same branch in one cycle, the lookup reports the counter as it was before that update; a lookup of an address being allocated in the same cycle misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lkValid | input | 1 | Lookup request this cycle |
| lkAddr | input | ADDR_W | Address of the fetched branch |
| lkHit | output | 1 | Address found in the table |
| lkTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | Resolved branch presented this cycle |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest state to reach from the ports is a full table with a known recency order, because every lookup used to observe the table is itself a use that reorders it. The bench fills the table in a fixed order, then tracks by hand how each probing lookup and each refreshing update moves entries before it allocates a fresh address, so the victim it expects follows from the whole history. Saturation is reached by driving repeated identical outcomes and then a single opposite outcome, which only leaves the prediction unchanged if the counter truly held at its limit.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  // Two-bit signed counter values
  localparam logic [1:0] CNT_INIT = 2'b00;  // 0, weakly taken
  localparam logic [1:0] CNT_TOP  = 2'b01;  // +1
  localparam logic [1:0] CNT_BOT  = 2'b10;  // -2

  // Strobes from control to the entry store
  typedef struct packed {
    logic touchLk;   // lookup hit refreshes its entry
    logic touchUpd;  // update refreshes the written entry
    logic bumpCnt;   // step the counter of a present entry
    logic allocNew;  // claim the victim entry for a new address
    logic dirTaken;  // resolved outcome
  } bptCmd_t;

endpackage

// File: rtl/bpt_ctrl.sv
module bpt_ctrl
  import bpt_pkg::*;
(
  input  logic    lkValid,
  input  logic    lkFound,
  input  logic    lkSign,
  input  logic    updValid,
  input  logic    updFound,
  input  logic    updTaken,
  output bptCmd_t cmd,
  output logic    lkHit,
  output logic    lkTaken
);

  always_comb begin
    lkHit        = lkValid & lkFound;
    lkTaken      = lkHit & ~lkSign;
    cmd.touchLk  = lkHit;
    cmd.touchUpd = updValid;
    cmd.bumpCnt  = updValid & updFound;
    cmd.allocNew = updValid & ~updFound;
    cmd.dirTaken = updTaken;
  end

endmodule

// File: rtl/bpt_store.sv
module bpt_store
  import bpt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ADDR_W-1:0] updAddr,
  input  bptCmd_t           cmd,
  output logic              lkFound,
  output logic              lkSign,
  output logic              updFound
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ADDR_W-1:0] tagQ   [ENTRIES];
  logic [1:0]        cntQ   [ENTRIES];
  logic [IDX_W-1:0]  ageQ   [ENTRIES];
  logic [IDX_W-1:0]  ageMid [ENTRIES];
  logic [IDX_W-1:0]  ageNext[ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] updMatch;
  logic [IDX_W-1:0]  lkIdx;
  logic [IDX_W-1:0]  updIdx;
  logic [IDX_W-1:0]  victimIdx;
  logic [IDX_W-1:0]  wrIdx;

  // Tag comparators, one pair per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lkMatch[g]  = validQ[g] && (tagQ[g] == lkAddr);
    assign updMatch[g] = validQ[g] && (tagQ[g] == updAddr);
  end

  // One-hot to index; tags are unique so at most one bit is set
  always_comb begin
    lkIdx  = '0;
    updIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i])  lkIdx  = lkIdx  | IDX_W'(i);
      if (updMatch[i]) updIdx = updIdx | IDX_W'(i);
    end
  end

  assign lkFound  = |lkMatch;
  assign updFound = |updMatch;
  assign lkSign   = cntQ[lkIdx][1];

  // Recency after the lookup touch (age 0 = newest)
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ageMid[i] = ageQ[i];
      if (cmd.touchLk) begin
        if (IDX_W'(i) == lkIdx)         ageMid[i] = '0;
        else if (ageQ[i] < ageQ[lkIdx]) ageMid[i] = ageQ[i] + 1'b1;
      end
    end
  end

  // Victim is the oldest after the lookup touch; empty entries are
  // always older than used ones, so they are taken first
  always_comb begin
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ageMid[i] == OLDEST) victimIdx = victimIdx | IDX_W'(i);
    end
  end

  assign wrIdx = cmd.bumpCnt ? updIdx : victimIdx;

  // Recency after the update touch
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ageNext[i] = ageMid[i];
      if (cmd.touchUpd) begin
        if (IDX_W'(i) == wrIdx)             ageNext[i] = '0;
        else if (ageMid[i] < ageMid[wrIdx]) ageNext[i] = ageMid[i] + 1'b1;
      end
    end
  end

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    if (up) return (cur == CNT_TOP) ? cur : cur + 2'b01;
    else    return (cur == CNT_BOT) ? cur : cur - 2'b01;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i] <= '0;
        cntQ[i] <= CNT_INIT;
        ageQ[i] <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= ageNext[i];
      if (cmd.allocNew) begin
        tagQ[wrIdx]   <= updAddr;
        cntQ[wrIdx]   <= CNT_INIT;
        validQ[wrIdx] <= 1'b1;
      end
      if (cmd.bumpCnt) cntQ[wrIdx] <= satStep(cntQ[wrIdx], cmd.dirTaken);
    end
  end

endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table
  import bpt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic              lkTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  bptCmd_t cmd;
  logic    lkFound;
  logic    lkSign;
  logic    updFound;

  bpt_ctrl i_ctrl (
    .lkValid (lkValid),
    .lkFound (lkFound),
    .lkSign  (lkSign),
    .updValid(updValid),
    .updFound(updFound),
    .updTaken(updTaken),
    .cmd     (cmd),
    .lkHit   (lkHit),
    .lkTaken (lkTaken)
  );

  bpt_store #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) i_store (
    .clk     (clk),
    .rst     (rst),
    .lkAddr  (lkAddr),
    .updAddr (updAddr),
    .cmd     (cmd),
    .lkFound (lkFound),
    .lkSign  (lkSign),
    .updFound(updFound)
  );

endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lkValid,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic              lkTaken,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic              updTaken
);

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lkValid) |-> !lkHit);  // R1

  AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!lkHit || !lkValid) |-> (!lkTaken && (lkValid || !lkHit)));  // R2

  AST_UPDATE_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(updValid) && lkValid && lkAddr == $past(updAddr))
      |-> lkHit);  // R3

  AST_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lkValid && lkHit && lkTaken && updValid && updTaken
                          && updAddr == lkAddr)
       && lkValid && lkAddr == $past(lkAddr))
      |-> (lkHit && lkTaken));  // R5

  AST_NOT_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lkValid && lkHit && !lkTaken && updValid && !updTaken
                          && updAddr == lkAddr)
       && lkValid && lkAddr == $past(lkAddr))
      |-> (lkHit && !lkTaken));  // R6

endmodule

bind bp_dir_table bpt_checker #(.ADDR_W(ADDR_W)) i_bpt_checker (
  .clk     (clk),
  .rst     (rst),
  .lkValid (lkValid),
  .lkAddr  (lkAddr),
  .lkHit   (lkHit),
  .lkTaken (lkTaken),
  .updValid(updValid),
  .updAddr (updAddr),
  .updTaken(updTaken)
);

// File: tb/test_bp_dir_table.sv
`timescale 1ns/1ps
module test_bp_dir_table;

  localparam int ENTRIES = 8;
  localparam int ADDR_W  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lkValid = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic              lkHit;
  logic              lkTaken;
  logic              updValid = 1'b0;
  logic [ADDR_W-1:0] updAddr = '0;
  logic              updTaken = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  bp_dir_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_bp_dir_table (
    .clk(clk), .rst(rst),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkHit(lkHit), .lkTaken(lkTaken),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; lkValid = 1'b0; updValid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Lookup: results sampled between edges, touch lands at next edge
  task automatic look(input logic [ADDR_W-1:0] a, input string req,
                      input logic expHit, input logic expTaken);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a;
    #1;
    check({req, " hit"}, lkHit, expHit);
    check({req, " taken"}, lkTaken, expTaken);
    @(posedge clk);
    #1 lkValid = 1'b0;
  endtask

  task automatic upd(input logic [ADDR_W-1:0] a, input logic t);
    @(negedge clk);
    updValid = 1'b1; updAddr = a; updTaken = t;
    @(posedge clk);
    #1 updValid = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    look(32'h100, "R1", 1'b0, 1'b0);
    upd(32'h100, 1'b1);
    look(32'h100, "R3", 1'b1, 1'b1);
    doReset();
    look(32'h100, "R1", 1'b0, 1'b0);
    look(32'h204, "R2", 1'b0, 1'b0);
  endtask

  task automatic tAlloc();
    doReset();
    upd(32'h300, 1'b0);  // allocation ignores outcome, starts at 0
    look(32'h300, "R3", 1'b1, 1'b1);
    look(32'h304, "R2", 1'b0, 1'b0);
    // lkValid low: no hit, no prediction on a present address
    @(negedge clk);
    lkValid = 1'b0; lkAddr = 32'h300;
    #1;
    check("R2 idle hit", lkHit, 1'b0);
    check("R2 idle taken", lkTaken, 1'b0);
  endtask

  task automatic tSatUp();
    doReset();
    upd(32'h400, 1'b1);                 // 0
    upd(32'h400, 1'b1);                 // +1
    look(32'h400, "R4", 1'b1, 1'b1);
    upd(32'h400, 1'b1);                 // held at +1
    upd(32'h400, 1'b1);
    upd(32'h400, 1'b0);                 // 0
    look(32'h400, "R5", 1'b1, 1'b1);
    upd(32'h400, 1'b0);                 // -1
    look(32'h400, "R4", 1'b1, 1'b0);
  endtask

  task automatic tSatDown();
    doReset();
    upd(32'h500, 1'b1);                 // alloc 0
    upd(32'h500, 1'b0);                 // -1
    look(32'h500, "R6", 1'b1, 1'b0);
    upd(32'h500, 1'b0);                 // -2
    upd(32'h500, 1'b0);                 // held
    upd(32'h500, 1'b0);
    upd(32'h500, 1'b1);                 // -1
    look(32'h500, "R6", 1'b1, 1'b0);
    upd(32'h500, 1'b1);                 // 0
    look(32'h500, "R6", 1'b1, 1'b1);
  endtask

  task automatic tSameCycle();
    doReset();
    upd(32'h600, 1'b1);                 // 0
    upd(32'h600, 1'b0);                 // -1
    @(negedge clk);
    lkValid = 1'b1; lkAddr = 32'h600;
    updValid = 1'b1; updAddr = 32'h600; updTaken = 1'b1;
    #1;
    check("R9 pre-update taken", lkTaken, 1'b0);
    @(posedge clk);
    #1 lkValid = 1'b0; updValid = 1'b0;
    look(32'h600, "R9 post-update", 1'b1, 1'b1);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = 32'h604;
    updValid = 1'b1; updAddr = 32'h604; updTaken = 1'b1;
    #1;
    check("R9 alloc same cycle hit", lkHit, 1'b0);
    @(posedge clk);
    #1 lkValid = 1'b0; updValid = 1'b0;
    look(32'h604, "R9 allocated", 1'b1, 1'b1);
  endtask

  task automatic tLru();
    doReset();
    for (int i = 0; i < ENTRIES; i++) upd(32'h1000 + 32'(i * 4), 1'b1);
    // order oldest..newest: A0..A7; lookups below touch each in turn
    for (int i = 0; i < ENTRIES; i++) look(32'h1000 + 32'(i * 4), "R7", 1'b1, 1'b1);
    // still A0..A7; refresh A0 -> A1..A7,A0
    look(32'h1000, "R8 refresh", 1'b1, 1'b1);
    upd(32'h2000, 1'b1);                // evicts A1
    look(32'h1000, "R8 kept", 1'b1, 1'b1);
    look(32'h1004, "R8 evicted", 1'b0, 1'b0);   // miss: no touch
    look(32'h2000, "R8 new", 1'b1, 1'b1);
    // order A2..A7,A0,B; refresh A2 via update
    upd(32'h1008, 1'b1);
    upd(32'h2004, 1'b1);                // evicts A3
    look(32'h100c, "R8 evicted by age", 1'b0, 1'b0);
    look(32'h1008, "R8 update refresh", 1'b1, 1'b1);
    look(32'h2004, "R8 new", 1'b1, 1'b1);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    tReset();
    tAlloc();
    tSatUp();
    tSatDown();
    tSameCycle();
    tLru();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule